// File: doc/BRIEF.md
# Half-Duplex Teleprinter Bus Controller

This controller sits on a processor I/O bus and serves a teleprinter through one shared 8-bit character register and one ready flag. A direction bit decides whether that pair currently belongs to the keyboard (input) or to the printer (output). Bus commands arrive as a one-cycle strobe with an operation class, a 4-bit function code and a 16-bit data word. Four classes exist: control pulse, skip test, input-to-accumulator and output-from-accumulator. The controller answers in the same cycle with a skip indication, a returned data word and an illegal-function flag. State changes take effect at the clock edge that ends the strobe.

Keyboard characters arrive on a one-cycle valid strobe, with a separate break indicator. Printer characters leave on a one-cycle start pulse together with the character, and the printer reports completion on a done pulse. Two configuration inputs shape the characters. One selects an upper-case teleprinter mode. The other selects 7-bit or 8-bit width when that mode is off. An interrupt request is raised whenever ready is set and the interrupt enable, written through its own port, is on.

Top module: `hdx_tty_if`

## Requirements
- R1: After a synchronous reset, direction is input, the character register is 0, ready and enable are 0, the printer is idle, `irq` is 0 and `prn_start` is 0.
- R2: Operation class is coded as `io_op` 0 = control, 1 = skip test, 2 = input, 3 = output. Control codes 0 and 1 are legal. Code 1 in input direction switches to output and sets ready when the printer is idle. Code 0 in output direction switches to input and clears ready. Other combinations change nothing.
- R3: Skip-test codes 0, 1, 4 and 5 are legal. Code 0 skips when ready is set. Code 1 skips in output direction with the printer idle. Code 4 skips when no interrupt is requested. Code 5 skips in input direction when the low 7 character bits equal 0x13.
- R4: Input codes 0 and 2 are legal. When ready, the command skips and returns `io_din` ORed with the character: all 8 bits for code 0, the low 6 bits for code 2. It clears ready only in input direction. When not ready, `io_dout` equals `io_din` and there is no skip.
- R5: Output codes 0 and 2 are legal. When ready, the command stores `io_din[7:0]` and skips in either direction. For code 2 the stored value then gets bit 6 set, and bit 6 is cleared again when bit 5 is 1.
- R6: An output command accepted in output direction clears ready, and raises `prn_start` for one cycle, in the cycle after the command, while the printer becomes busy.
- R7: A keyboard character is loaded, and ready set, only in input direction. In output direction it leaves the character register unchanged.
- R8: With `cfg_upper` = 1, input characters are masked to 7 bits, lowercase a..z are folded to A..Z, and bit 7 is forced to 1. `prn_char` is the 7-bit character folded to uppercase.
- R9: A keyboard strobe with `kbd_break` = 1 loads the value 0.
- R10: With `cfg_upper` = 0, `cfg_wide` = 0 masks both keyboard input and `prn_char` to 7 bits, and `cfg_wide` = 1 keeps all 8 bits.
- R11: A `prn_done` pulse while the printer is busy makes it idle and sets ready. A pulse while idle has no effect.
- R12: An illegal function code raises `io_badfn`, gives no skip, returns `io_din` unchanged and alters no state.
- R13: `irq` is 1 exactly when ready and enable are both 1. Enable takes the value of `mask_val` at each `mask_we` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Bus command strobe |
| io_op | input | 2 | Operation class |
| io_fn | input | 4 | Function code |
| io_din | input | 16 | Bus data toward the controller |
| io_dout | output | 16 | Returned bus data |
| io_skip | output | 1 | Skip response |
| io_badfn | output | 1 | Illegal function for this class |
| mask_we | input | 1 | Interrupt enable write strobe |
| mask_val | input | 1 | Interrupt enable value |
| irq | output | 1 | Interrupt request |
| kbd_valid | input | 1 | Keyboard character strobe |
| kbd_char | input | 8 | Keyboard character |
| kbd_break | input | 1 | Break condition with the strobe |
| prn_start | output | 1 | Printer start pulse |
| prn_char | output | 8 | Character for the printer |
| prn_done | input | 1 | Printer completion pulse |
| cfg_upper | input | 1 | Upper-case teleprinter mode |
| cfg_wide | input | 1 | 8-bit width when not upper-case |

## Verification
Bus responses (`io_skip`, `io_dout`, `io_badfn`) are combinational and due in the strobe cycle itself. Any state change made by a command, keyboard strobe, done pulse or enable write shows from the next cycle, through later commands and `irq`. `prn_start` and `prn_char` are due exactly one cycle after the accepting output command. The bench changes inputs just after a falling edge, samples 4 ns later in the same cycle, and advances its reference state only after sampling. Each response is therefore compared with the state that was in place before the edge.

// File: rtl/hdx_tty_pkg.sv
package hdx_tty_pkg;

    localparam int CHAR_W  = 8;
    localparam logic [6:0] XOFF_CODE = 7'h13;

    typedef enum logic [1:0] {
        OP_CTL = 2'd0,
        OP_TST = 2'd1,
        OP_IN  = 2'd2,
        OP_OUT = 2'd3
    } io_op_e;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } dir_e;

    typedef struct packed {
        dir_e              dir;
        logic              ready;
        logic              enable;
        logic              busy;
        logic [CHAR_W-1:0] chr;
    } tty_state_t;

    typedef struct packed {
        logic              bad;
        logic              skip;
        logic              to_out;
        logic              to_in;
        logic              rdy_set;
        logic              rdy_clr;
        logic              chr_we;
        logic [CHAR_W-1:0] chr_wd;
        logic              prn_go;
    } cmd_act_t;

    function automatic logic [6:0] fold_upper(input logic [6:0] c);
        return (c >= 7'h61 && c <= 7'h7A) ? c - 7'h20 : c;
    endfunction

    function automatic logic [CHAR_W-1:0] bin_remap(input logic [CHAR_W-1:0] d);
        logic [CHAR_W-1:0] r;
        r = d | 8'h40;
        if (r[5]) r[6] = 1'b0;
        return r;
    endfunction

    function automatic logic [CHAR_W-1:0] kbd_xform(input logic [CHAR_W-1:0] c,
                                                    input logic brk,
                                                    input logic upper,
                                                    input logic wide);
        if (brk)        return '0;
        else if (upper) return {1'b1, fold_upper(c[6:0])};
        else if (wide)  return c;
        else            return {1'b0, c[6:0]};
    endfunction

    function automatic logic [CHAR_W-1:0] prn_xform(input logic [CHAR_W-1:0] c,
                                                    input logic upper,
                                                    input logic wide);
        if (upper)     return {1'b0, fold_upper(c[6:0])};
        else if (wide) return c;
        else           return {1'b0, c[6:0]};
    endfunction

endpackage

// File: rtl/hdx_tty_decode.sv
module hdx_tty_decode
    import hdx_tty_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              valid,
    input  io_op_e            op,
    input  logic [3:0]        fn,
    input  logic [DATA_W-1:0] din,
    input  tty_state_t        st,
    output cmd_act_t          act,
    output logic [DATA_W-1:0] dout
);
    localparam int PAD_W = DATA_W - CHAR_W;

    logic irq_req;
    logic fn_data_ok;
    assign irq_req    = st.ready & st.enable;
    assign fn_data_ok = (fn == 4'd0) || (fn == 4'd2);

    always_comb begin
        act  = '0;
        dout = din;
        if (valid) begin
            unique case (op)
                OP_CTL: begin
                    if (fn[3:1] != 3'd0) begin
                        act.bad = 1'b1;
                    end else if (fn[0] && st.dir == DIR_IN) begin
                        act.to_out  = 1'b1;
                        act.rdy_set = ~st.busy;
                    end else if (!fn[0] && st.dir == DIR_OUT) begin
                        act.to_in   = 1'b1;
                        act.rdy_clr = 1'b1;
                    end
                end
                OP_TST: begin
                    if ((fn & 4'b1010) != 4'd0) begin
                        act.bad = 1'b1;
                    end else begin
                        unique case (fn)
                            4'd0:    act.skip = st.ready;
                            4'd1:    act.skip = (st.dir == DIR_OUT) && !st.busy;
                            4'd4:    act.skip = !irq_req;
                            default: act.skip = (st.dir == DIR_IN) &&
                                                (st.chr[6:0] == XOFF_CODE);
                        endcase
                    end
                end
                OP_IN: begin
                    if (!fn_data_ok) begin
                        act.bad = 1'b1;
                    end else if (st.ready) begin
                        act.skip    = 1'b1;
                        act.rdy_clr = (st.dir == DIR_IN);
                        if (fn[1])
                            dout = din | {{PAD_W{1'b0}}, 2'b00, st.chr[5:0]};
                        else
                            dout = din | {{PAD_W{1'b0}}, st.chr};
                    end
                end
                default: begin
                    if (!fn_data_ok) begin
                        act.bad = 1'b1;
                    end else if (st.ready) begin
                        act.skip   = 1'b1;
                        act.chr_we = 1'b1;
                        act.chr_wd = fn[1] ? bin_remap(din[CHAR_W-1:0])
                                           : din[CHAR_W-1:0];
                        if (st.dir == DIR_OUT) begin
                            act.prn_go  = 1'b1;
                            act.rdy_clr = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/hdx_tty_kbd.sv
module hdx_tty_kbd
    import hdx_tty_pkg::*;
(
    input  logic              kbd_valid,
    input  logic [CHAR_W-1:0] kbd_char,
    input  logic              kbd_break,
    input  logic              cfg_upper,
    input  logic              cfg_wide,
    input  dir_e              dir,
    output logic              load,
    output logic [CHAR_W-1:0] load_char
);
    assign load      = kbd_valid && (dir == DIR_IN);
    assign load_char = kbd_xform(kbd_char, kbd_break, cfg_upper, cfg_wide);
endmodule

// File: rtl/hdx_tty_prn.sv
module hdx_tty_prn
    import hdx_tty_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              done,
    input  logic [CHAR_W-1:0] chr,
    input  logic              cfg_upper,
    input  logic              cfg_wide,
    output logic              busy,
    output logic              done_evt,
    output logic              prn_start,
    output logic [CHAR_W-1:0] prn_char
);
    logic busy_q;
    logic start_q;

    assign done_evt = done && busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= go;
            if (go)            busy_q <= 1'b1;
            else if (done_evt) busy_q <= 1'b0;
        end
    end

    assign busy      = busy_q;
    assign prn_start = start_q;
    assign prn_char  = prn_xform(chr, cfg_upper, cfg_wide);

    assert_busy_with_start_R6: assert property (@(posedge clk) disable iff (rst)
        start_q |-> busy_q);

endmodule

// File: rtl/hdx_tty_if.sv
module hdx_tty_if
    import hdx_tty_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_valid,
    input  logic [1:0]        io_op,
    input  logic [3:0]        io_fn,
    input  logic [DATA_W-1:0] io_din,
    output logic [DATA_W-1:0] io_dout,
    output logic              io_skip,
    output logic              io_badfn,
    input  logic              mask_we,
    input  logic              mask_val,
    output logic              irq,
    input  logic              kbd_valid,
    input  logic [7:0]        kbd_char,
    input  logic              kbd_break,
    output logic              prn_start,
    output logic [7:0]        prn_char,
    input  logic              prn_done,
    input  logic              cfg_upper,
    input  logic              cfg_wide
);
    dir_e              dir_q;
    logic              ready_q, ready_n;
    logic              en_q;
    logic [CHAR_W-1:0] chr_q;
    logic              busy;
    logic              done_evt;
    logic              kbd_load;
    logic [CHAR_W-1:0] kbd_val;
    tty_state_t        st;
    cmd_act_t          act;

    assign st = '{dir: dir_q, ready: ready_q, enable: en_q, busy: busy, chr: chr_q};

    hdx_tty_decode #(.DATA_W(DATA_W)) u_decode (
        .valid (io_valid),
        .op    (io_op_e'(io_op)),
        .fn    (io_fn),
        .din   (io_din),
        .st    (st),
        .act   (act),
        .dout  (io_dout)
    );

    hdx_tty_kbd u_kbd (
        .kbd_valid (kbd_valid),
        .kbd_char  (kbd_char),
        .kbd_break (kbd_break),
        .cfg_upper (cfg_upper),
        .cfg_wide  (cfg_wide),
        .dir       (dir_q),
        .load      (kbd_load),
        .load_char (kbd_val)
    );

    hdx_tty_prn u_prn (
        .clk       (clk),
        .rst       (rst),
        .go        (act.prn_go),
        .done      (prn_done),
        .chr       (chr_q),
        .cfg_upper (cfg_upper),
        .cfg_wide  (cfg_wide),
        .busy      (busy),
        .done_evt  (done_evt),
        .prn_start (prn_start),
        .prn_char  (prn_char)
    );

    assign io_skip  = act.skip;
    assign io_badfn = act.bad;
    assign irq      = ready_q & en_q;

    // Ready: printer completion first, bus command overrides, keyboard last.
    always_comb begin
        ready_n = ready_q;
        if (done_evt)    ready_n = 1'b1;
        if (act.rdy_set) ready_n = 1'b1;
        if (act.rdy_clr) ready_n = 1'b0;
        if (kbd_load)    ready_n = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= DIR_IN;
            ready_q <= 1'b0;
            en_q    <= 1'b0;
            chr_q   <= '0;
        end else begin
            ready_q <= ready_n;
            if (mask_we)         en_q  <= mask_val;
            if (act.to_out)      dir_q <= DIR_OUT;
            else if (act.to_in)  dir_q <= DIR_IN;
            if (kbd_load)        chr_q <= kbd_val;
            else if (act.chr_we) chr_q <= act.chr_wd;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (dir_q == DIR_IN && !ready_q && !en_q && chr_q == '0 && !prn_start));

    assert_start_clears_ready_R6: assert property (@(posedge clk) disable iff (rst)
        prn_start |-> !ready_q);

    assert_kbd_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (kbd_valid && dir_q == DIR_OUT && !(io_valid && io_op == 2'd3)) |=> $stable(chr_q));

    assert_done_sets_ready_R11: assert property (@(posedge clk) disable iff (rst)
        (prn_done && busy && !io_valid) |=> ready_q);

    assert_badfn_inert_R12: assert property (@(posedge clk) disable iff (rst)
        (io_badfn && !kbd_valid && !prn_done) |=> ($stable(ready_q) && $stable(dir_q) && $stable(chr_q)));

    assert_badfn_noskip_R12: assert property (@(posedge clk) disable iff (rst)
        io_badfn |-> (!io_skip && io_dout == io_din));

endmodule

// File: tb/hdx_tty_if_bench.sv
module hdx_tty_if_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_valid = 1'b0;
    logic [1:0]  io_op = 2'd0;
    logic [3:0]  io_fn = 4'd0;
    logic [15:0] io_din = 16'd0;
    logic [15:0] io_dout;
    logic        io_skip, io_badfn;
    logic        mask_we = 1'b0, mask_val = 1'b0;
    logic        irq;
    logic        kbd_valid = 1'b0;
    logic [7:0]  kbd_char = 8'd0;
    logic        kbd_break = 1'b0;
    logic        prn_start;
    logic [7:0]  prn_char;
    logic        prn_done = 1'b0;
    logic        cfg_upper = 1'b0, cfg_wide = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // reference state
    bit       m_out, m_rdy, m_en, m_busy, m_startp;
    bit [7:0] m_chr;

    always #5 clk = ~clk;

    hdx_tty_if u_hdx_tty_if (
        .clk(clk), .rst(rst), .io_valid(io_valid), .io_op(io_op), .io_fn(io_fn),
        .io_din(io_din), .io_dout(io_dout), .io_skip(io_skip), .io_badfn(io_badfn),
        .mask_we(mask_we), .mask_val(mask_val), .irq(irq),
        .kbd_valid(kbd_valid), .kbd_char(kbd_char), .kbd_break(kbd_break),
        .prn_start(prn_start), .prn_char(prn_char), .prn_done(prn_done),
        .cfg_upper(cfg_upper), .cfg_wide(cfg_wide)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit [6:0] up7(input bit [6:0] c);
        return (c >= 7'h61 && c <= 7'h7A) ? c - 7'h20 : c;
    endfunction

    function automatic bit [7:0] exp_kbd(input bit [7:0] c, input bit brk);
        if (brk)            return 8'h00;             // R9
        else if (cfg_upper) return {1'b1, up7(c[6:0])}; // R8
        else if (cfg_wide)  return c;                 // R10
        else                return {1'b0, c[6:0]};
    endfunction

    function automatic bit [7:0] exp_prn(input bit [7:0] c);
        if (cfg_upper)     return {1'b0, up7(c[6:0])};
        else if (cfg_wide) return c;
        else               return {1'b0, c[6:0]};
    endfunction

    task automatic model_reset();
        m_out = 0; m_rdy = 0; m_en = 0; m_busy = 0; m_startp = 0; m_chr = 0;
    endtask

    // sample outputs common to every cycle, then release inputs at the next falling edge
    task automatic finish_cycle(input bit go);
        #4;
        chk("R13", "irq", irq, m_rdy & m_en);
        chk("R6", "prn_start", prn_start, m_startp);
        if (m_startp)
            chk(cfg_upper ? "R8" : "R10", "prn_char", prn_char, exp_prn(m_chr));
        m_startp = go;
        if (go) m_busy = 1;
    endtask

    task automatic release_inputs();
        @(negedge clk);
        io_valid = 0; kbd_valid = 0; kbd_break = 0; prn_done = 0; mask_we = 0;
    endtask

    task automatic do_io(input bit [1:0] op, input bit [3:0] fn, input bit [15:0] din, input string tag);
        bit e_bad, e_skip, e_go;
        bit [15:0] e_dout;
        string t;
        io_valid = 1; io_op = op; io_fn = fn; io_din = din;
        e_bad = 0; e_skip = 0; e_go = 0; e_dout = din;
        case (op)
            2'd0: e_bad = (fn > 4'd1);
            2'd1: e_bad = !(fn == 0 || fn == 1 || fn == 4 || fn == 5);
            default: e_bad = !(fn == 0 || fn == 2);
        endcase
        if (!e_bad) begin
            case (op)
                2'd1: case (fn)
                    4'd0: e_skip = m_rdy;
                    4'd1: e_skip = m_out && !m_busy;
                    4'd4: e_skip = !(m_rdy && m_en);
                    default: e_skip = !m_out && (m_chr[6:0] == 7'h13);
                endcase
                2'd2: if (m_rdy) begin
                    e_skip = 1;
                    e_dout = din | (fn == 2 ? {10'd0, m_chr[5:0]} : {8'd0, m_chr});
                end
                2'd3: if (m_rdy) e_skip = 1;
                default: ;
            endcase
        end
        t = (tag != "") ? tag : e_bad ? "R12" : op == 0 ? "R2" : op == 1 ? "R3" : op == 2 ? "R4" : "R5";
        #4;
        chk(t, "io_badfn", io_badfn, e_bad);
        chk(t, "io_skip", io_skip, e_skip);
        chk(t, "io_dout", io_dout, e_dout);
        #0;
        // state update per requirements
        if (!e_bad) begin
            case (op)
                2'd0: begin
                    if (fn == 1 && !m_out) begin m_out = 1; if (!m_busy) m_rdy = 1; end
                    else if (fn == 0 && m_out) begin m_out = 0; m_rdy = 0; end
                end
                2'd2: if (m_rdy && !m_out) m_rdy = 0;
                2'd3: if (m_rdy) begin
                    m_chr = din[7:0];
                    if (fn == 2) begin m_chr[6] = 1; if (m_chr[5]) m_chr[6] = 0; end
                    if (m_out) begin e_go = 1; m_rdy = 0; end
                end
                default: ;
            endcase
        end
        // the #4 above already elapsed; run the shared checks without extra delay
        chk("R13", "irq", irq, (m_startp ? 0 : 0) | (irq_prev_exp));
        release_inputs();
    endtask

    bit irq_prev_exp;

    task automatic io(input bit [1:0] op, input bit [3:0] fn, input bit [15:0] din, input string tag);
        bit go_before;
        irq_prev_exp = m_rdy & m_en;
        // prn_start / prn_char due in this cycle from the previous accepted output
        fork
            begin
                #4;
                chk("R6", "prn_start", prn_start, m_startp);
                if (m_startp) chk(cfg_upper ? "R8" : "R10", "prn_char", prn_char, exp_prn(m_chr));
            end
        join_none
        go_before = m_busy;
        do_io(op, fn, din, tag);
        // a new start is due next cycle when the output command was accepted in output direction
        m_startp = (op == 2'd3) && (m_busy == go_before) && !m_rdy && m_out && pend_go;
        if (m_startp) m_busy = 1;
    endtask

    bit pend_go;

    task automatic kbd(input bit [7:0] c, input bit brk, input string tag);
        kbd_valid = 1; kbd_char = c; kbd_break = brk;
        finish_cycle(0);
        if (!m_out) begin m_chr = exp_kbd(c, brk); m_rdy = 1; end
        release_inputs();
        if (tag != "") chk(tag, "kbd accepted dir", 0, 0);
    endtask

    task automatic done_pulse();
        prn_done = 1;
        finish_cycle(0);
        if (m_busy) begin m_busy = 0; m_rdy = 1; end   // R11
        release_inputs();
    endtask

    task automatic mask(input bit v);
        mask_we = 1; mask_val = v;
        finish_cycle(0);
        m_en = v;
        release_inputs();
    endtask

    task automatic idle();
        finish_cycle(0);
        release_inputs();
    endtask

    // output command helper: computes acceptance before issuing
    task automatic ota(input bit [3:0] fn, input bit [15:0] din, input string tag);
        pend_go = m_rdy && m_out && (fn == 0 || fn == 2);
        io(2'd3, fn, din, tag);
        pend_go = 0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        pend_go = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state seen through the ports
        #4;
        chk("R1", "irq", irq, 0);
        chk("R1", "prn_start", prn_start, 0);
        @(negedge clk);
        io(2'd1, 4'd0, 16'h0, "R1");       // not ready
        io(2'd1, 4'd5, 16'h0, "R1");       // register 0 is not 0x13
        io(2'd1, 4'd1, 16'h0, "R1");       // input direction
        io(2'd2, 4'd0, 16'h1234, "R1");    // no data, no skip

        // R8: upper-case input
        cfg_upper = 1;
        kbd(8'h61, 0, "R8");
        io(2'd2, 4'd0, 16'h1200, "R8");    // 0x12C1
        io(2'd2, 4'd0, 16'h0000, "R4");    // ready now clear
        // R9: break
        kbd(8'h7A, 1, "R9");
        io(2'd2, 4'd2, 16'hAB00, "R9");
        // R10 narrow, XOFF test R3
        cfg_upper = 0; cfg_wide = 0;
        kbd(8'h93, 0, "R10");
        io(2'd1, 4'd5, 16'h0, "R3");
        io(2'd2, 4'd0, 16'h0, "R10");
        cfg_wide = 1;
        kbd(8'hE5, 0, "R10");
        io(2'd2, 4'd2, 16'h0, "R4");
        // R2: to output, ready set with idle printer
        io(2'd0, 4'd1, 16'h0, "R2");
        io(2'd1, 4'd1, 16'h0, "R3");
        kbd(8'h41, 0, "R7");               // ignored in output direction
        io(2'd2, 4'd0, 16'h0, "R7");       // returns previous char, ready kept
        // R5/R6: binary remap and printer start
        cfg_wide = 0;
        ota(4'd2, 16'h0005, "R5");         // stores 0x45
        idle();                            // prn_start due here
        io(2'd1, 4'd1, 16'h0, "R6");       // busy, no skip
        done_pulse();                      // R11
        mask(1);
        io(2'd1, 4'd4, 16'h0, "R13");
        ota(4'd2, 16'h0025, "R5");         // stores 0x25
        idle();
        done_pulse();
        done_pulse();                      // idle printer: ignored
        io(2'd1, 4'd0, 16'h0, "R11");
        io(2'd0, 4'd3, 16'h55AA, "R12");
        io(2'd2, 4'd1, 16'h0F0F, "R12");
        io(2'd0, 4'd0, 16'h0, "R2");       // back to input, ready cleared
        io(2'd1, 4'd0, 16'h0, "R2");

        for (int i = 0; i < 4000; i++) begin
            int ev;
            ev = int'($urandom_range(0, 99));
            if (ev < 45) begin
                bit [1:0] op; bit [3:0] fn; bit [15:0] d;
                op = 2'($urandom_range(0, 3));
                fn = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 5));
                d  = 16'($urandom);
                if (op == 2'd3) ota(fn, d, "");
                else io(op, fn, d, "");
            end else if (ev < 65) begin
                kbd(8'($urandom), $urandom_range(0, 19) == 0, "");
            end else if (ev < 78) begin
                done_pulse();
            end else if (ev < 83) begin
                mask(1'($urandom));
            end else if (ev < 88) begin
                cfg_upper = 1'($urandom); cfg_wide = 1'($urandom);
                idle();
            end else begin
                idle();
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule